// File: doc/BRIEF.md
# Command-Routed Serial Register Interface

This block is the serial slave side of a converter. A host reaches a small bank of registers over five signals: an active-low select, a serial clock, a data input, a data output and an active-low data-ready flag. Each access has two phases. First the host shifts in a command byte. That byte names a register and says whether the next phase reads it or writes it. Then the data phase follows, and its length is the width of the named register. After reset, and after every data phase, the interface waits for a new command byte.

Two conversion sources, a 24-bit main result and a 16-bit auxiliary result, hand new words to the block through one-cycle update strobes. The ready flag goes high for one clock before each output register update, so the host knows not to start a read. It then goes low once a result is in place. It goes high again only when every pending result has been read out through its data register. The same word can still be read again after the flag has returned high.

The link works with select held low all the time (three-wire use). It also works with select pulsed as a frame sync, where the falling edge of select puts the MSB on the data output. The serial inputs are treated as synchronous to the system clock and are sampled by it.

Top module: `ser_reg_if`

## Requirements
- R1: After reset rdy_no is 1, sdo_o is 0 while cs_ni is high, the mode register is 0x00, and the next 8 bits clocked in are taken as a command byte.
- R2: Command byte layout: bit 7 and bits 5:4 must be 0, bit 6 is 1 for read and 0 for write, and bits 3:0 are the address. Address map: 1 = status (read, 8 bits), 2 = mode (read/write, 8 bits), 3 = main data (read, MAIN_W bits), 4 = aux data (read, AUX_W bits). Any other command byte is ignored, and the next 8 bits are again taken as a command.
- R3: Command 0x02 followed by 8 data bits writes the mode register. Bits are sampled MSB first on rising sclk_i edges.
- R4: A read command is followed by a data phase as long as the register width. Data is shifted MSB first, and sdo_o changes only on falling sclk_i edges. Reading the mode register returns the last value written.
- R5: On the second clock after an update strobe, the new word is in the output register and that source is marked ready, so rdy_no is 0.
- R6: In the clock after an update strobe, rdy_no is 1 even when results are already pending.
- R7: A completed main-data read clears the main ready bit, and a completed aux-data read clears the aux ready bit. rdy_no is low while either bit is set. An update arriving in the same clock as a clear takes priority. The status register returns the aux ready bit in bit 1 and the main ready bit in bit 0, with the other bits 0. Reading a data register again returns the same word.
- R8: With cs_ni held low through every phase (three-wire use), command, write and read phases work back to back.
- R9: In frame-sync use, a falling cs_ni edge while a read is armed puts the MSB on sdo_o before any sclk_i edge. sclk_i edges while cs_ni is high are ignored.
- R10: A rising cs_ni edge after a partial byte or partial data phase aborts the transaction: nothing is written, and the next bits are taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| rdy_no | output | 1 | Data ready, active low |
| main_upd_i | input | 1 | Main source update strobe |
| main_data_i | input | MAIN_W | Main source result |
| aux_upd_i | input | 1 | Aux source update strobe |
| aux_data_i | input | AUX_W | Aux source result |

## Verification
The bench builds the block with its default widths: a 24-bit main register, a 16-bit aux register and 8-bit command, mode and status registers. This covers all three data-phase lengths and the left alignment of the shorter words on the output. A behavioural ready model is compared with rdy_no on every clock, through strobes, back-to-back updates and read clears. Serial scenarios cover the ignored command, the aborted write, three-wire use and frame-sync use with sclk_i running while cs_ni is high.

// File: rtl/sri_pkg.sv
package sri_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} sri_state_e;
  localparam int unsigned CMD_W = 8;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_MODE = 4'd2;
  localparam logic [3:0] A_MAIN = 4'd3;
  localparam logic [3:0] A_AUX  = 4'd4;
endpackage

// File: rtl/sri_result.sv
module sri_result #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  output logic         busy_o,
  output logic         rdy_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      busy_o  <= 1'b0;
      rdy_o   <= 1'b0;
      q_o     <= '0;
    end else begin
      busy_o <= upd_i;
      if (upd_i) stage_q <= data_i;
      if (busy_o) begin
        q_o   <= stage_q;
        rdy_o <= 1'b1;
      end else if (clr_i) begin
        rdy_o <= 1'b0;
      end
    end
  end

  assert_update_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> ##2 (rdy_o && q_o == $past(data_i, 2)));

  assert_clear_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !busy_o) |=> !rdy_o);
endmodule

// File: rtl/sri_serial.sv
module sri_serial
  import sri_pkg::*;
#(
  parameter int unsigned MAIN_W = 24,
  parameter int unsigned AUX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [1:0]        stat_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [AUX_W-1:0]  aux_i,
  output logic              clr_main_o,
  output logic              clr_aux_o
);
  localparam int unsigned LW = $clog2(MAIN_W + 1);

  sri_state_e        state_q;
  logic              sclk_q, cs_q, loaded_q;
  logic [LW-1:0]     bit_q, len_q, rd_len;
  logic [3:0]        sel_q;
  logic [CMD_W-2:0]  rx_q;
  logic [CMD_W-1:0]  mode_q, cmd_byte;
  logic [MAIN_W-1:0] tx_q, tx_load;
  logic              sclk_rise, sclk_fall, cs_fall, cs_rise, last_bit;
  logic              cmd_ok, rd_ok, wr_ok;

  assign sclk_rise = !cs_ni && sclk_i && !sclk_q;
  assign sclk_fall = !cs_ni && !sclk_i && sclk_q;
  assign cs_fall   = cs_q && !cs_ni;
  assign cs_rise   = !cs_q && cs_ni;
  assign cmd_byte  = {rx_q, sdi_i};
  assign last_bit  = (bit_q == len_q - LW'(1));

  always_comb begin
    cmd_ok = !cmd_byte[7] && (cmd_byte[5:4] == 2'b00);
    unique case (cmd_byte[3:0])
      A_STAT, A_MODE: rd_len = LW'(CMD_W);
      A_MAIN:         rd_len = LW'(MAIN_W);
      A_AUX:          rd_len = LW'(AUX_W);
      default:        rd_len = '0;
    endcase
    rd_ok = cmd_ok && cmd_byte[6] && (rd_len != '0);
    wr_ok = cmd_ok && !cmd_byte[6] && (cmd_byte[3:0] == A_MODE);
  end

  // left-align the selected word so the MSB leaves first
  always_comb begin
    tx_load = '0;
    unique case (sel_q)
      A_STAT:  tx_load[MAIN_W-1 -: CMD_W] = {{(CMD_W-2){1'b0}}, stat_i};
      A_MODE:  tx_load[MAIN_W-1 -: CMD_W] = mode_q;
      A_MAIN:  tx_load = main_i;
      A_AUX:   tx_load[MAIN_W-1 -: AUX_W] = aux_i;
      default: tx_load = '0;
    endcase
  end

  assign clr_main_o = sclk_rise && state_q == ST_RD && last_bit && sel_q == A_MAIN;
  assign clr_aux_o  = sclk_rise && state_q == ST_RD && last_bit && sel_q == A_AUX;
  assign sdo_o      = cs_ni ? 1'b0 : tx_q[MAIN_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b1;
      cs_q     <= 1'b1;
      state_q  <= ST_CMD;
      bit_q    <= '0;
      len_q    <= LW'(CMD_W);
      sel_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      loaded_q <= 1'b0;
      mode_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (cs_rise && bit_q != '0) begin
        state_q <= ST_CMD;
        bit_q   <= '0;
        len_q   <= LW'(CMD_W);
      end else if (sclk_rise) begin
        rx_q  <= cmd_byte[CMD_W-2:0];
        bit_q <= last_bit ? '0 : bit_q + LW'(1);
        if (last_bit) begin
          unique case (state_q)
            ST_CMD: begin
              if (rd_ok) begin
                state_q  <= ST_RD;
                sel_q    <= cmd_byte[3:0];
                len_q    <= rd_len;
                loaded_q <= 1'b0;
              end else if (wr_ok) begin
                state_q <= ST_WR;
              end
            end
            ST_WR: begin
              mode_q  <= cmd_byte;
              state_q <= ST_CMD;
            end
            default: begin
              state_q <= ST_CMD;
              len_q   <= LW'(CMD_W);
            end
          endcase
        end
      end else if (state_q == ST_RD && !loaded_q && (cs_fall || sclk_fall)) begin
        tx_q     <= tx_load;
        loaded_q <= 1'b1;
      end else if (state_q == ST_RD && sclk_fall && bit_q != '0) begin
        tx_q <= tx_q << 1;
      end
    end
  end

  assert_abort_resets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && bit_q != '0) |=> (state_q == ST_CMD && bit_q == '0));

  assert_bit_in_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q < len_q);

  assert_mode_only_by_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WR) |=> $stable(mode_q));
endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if #(
  parameter int unsigned MAIN_W = 24,
  parameter int unsigned AUX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              rdy_no,
  input  logic              main_upd_i,
  input  logic [MAIN_W-1:0] main_data_i,
  input  logic              aux_upd_i,
  input  logic [AUX_W-1:0]  aux_data_i
);
  logic              main_busy, aux_busy, main_rdy, aux_rdy, clr_main, clr_aux;
  logic [MAIN_W-1:0] main_q;
  logic [AUX_W-1:0]  aux_q;
  logic              busy_any;

  sri_result #(.W(MAIN_W)) main_res_i (
    .clk_i, .rst_ni, .upd_i(main_upd_i), .data_i(main_data_i), .clr_i(clr_main),
    .busy_o(main_busy), .rdy_o(main_rdy), .q_o(main_q));

  sri_result #(.W(AUX_W)) aux_res_i (
    .clk_i, .rst_ni, .upd_i(aux_upd_i), .data_i(aux_data_i), .clr_i(clr_aux),
    .busy_o(aux_busy), .rdy_o(aux_rdy), .q_o(aux_q));

  sri_serial #(.MAIN_W(MAIN_W), .AUX_W(AUX_W)) serial_i (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i, .sdo_o,
    .stat_i({aux_rdy, main_rdy}), .main_i(main_q), .aux_i(aux_q),
    .clr_main_o(clr_main), .clr_aux_o(clr_aux));

  assign busy_any = main_busy || aux_busy;
  assign rdy_no   = !(main_rdy || aux_rdy) || busy_any;

  assert_rdy_falls_after_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> $past(busy_any));

  assert_strobe_raises_rdy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_upd_i || aux_upd_i) |=> rdy_no);
endmodule

// File: tb/ser_reg_if_tb_top.sv
module ser_reg_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdo, rdy_n;
  logic main_upd = 1'b0, aux_upd = 1'b0;
  logic [23:0] main_data = '0;
  logic [15:0] aux_data = '0;

  int vectors = 0, errors = 0;
  logic [1:0] busy_m = '0, rdy_m = '0, clr_req = '0;
  logic [23:0] rd;

  always #10 clk = ~clk;

  ser_reg_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .rdy_no(rdy_n), .main_upd_i(main_upd), .main_data_i(main_data),
    .aux_upd_i(aux_upd), .aux_data_i(aux_data));

  // behavioural ready model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= '0;
      rdy_m  <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (busy_m[s]) rdy_m[s] <= 1'b1;
        else if (clr_req[s]) rdy_m[s] <= 1'b0;
      end
      busy_m <= {aux_upd, main_upd};
    end
  end

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) check("R7 rdy_no vs model", {23'd0, rdy_n}, {23'd0, ~(|rdy_m) | (|busy_m)});
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic din, input int mark, output logic dout);
    sclk = 1'b0;
    ticks(2);
    dout = sdo;
    sdi = din;
    sclk = 1'b1;
    if (mark >= 0) clr_req[mark] = 1'b1;
    ticks(1);
    clr_req = '0;
    ticks(1);
  endtask

  task automatic xfer(input logic [23:0] w, input int n, input int mark, output logic [23:0] r);
    logic b;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_xfer(w[i], (i == 0) ? mark : -1, b);
      r[i] = b;
    end
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [23:0] w, input int n,
                     input int mark, output logic [23:0] r);
    logic [23:0] junk;
    cs_n = 1'b0;
    ticks(2);
    xfer({16'd0, cmd}, 8, -1, junk);
    if (n > 0) xfer(w, n, mark, r);
    ticks(2);
    cs_n = 1'b1;
    ticks(2);
  endtask

  task automatic load_main(input logic [23:0] d);
    main_data = d;
    main_upd = 1'b1;
    ticks(1);
    main_upd = 1'b0;
    check("R6 rdy_no high before update", {23'd0, rdy_n}, 24'd1);
    ticks(1);
    check("R5 rdy_no low after update", {23'd0, rdy_n}, 24'd0);
  endtask

  task automatic load_aux(input logic [15:0] d);
    aux_data = d;
    aux_upd = 1'b1;
    ticks(1);
    aux_upd = 1'b0;
    check("R6 rdy_no high before aux update", {23'd0, rdy_n}, 24'd1);
    ticks(1);
    check("R5 rdy_no low after aux update", {23'd0, rdy_n}, 24'd0);
  endtask

  initial begin
    logic [23:0] junk;
    ticks(3);
    check("R1 rdy_no at reset", {23'd0, rdy_n}, 24'd1);
    check("R1 sdo idle", {23'd0, sdo}, 24'd0);
    rst_n = 1'b1;
    ticks(2);
    txn(8'h42, 24'd0, 8, -1, rd);
    check("R1 mode reset value", rd, 24'h000000);

    txn(8'h02, 24'hA5, 8, -1, junk);
    txn(8'h42, 24'd0, 8, -1, rd);
    check("R3 mode write readback", rd, 24'h0000A5);

    load_main(24'h123456);
    txn(8'h41, 24'd0, 8, -1, rd);
    check("R7 status main ready", rd, 24'h000001);
    txn(8'h43, 24'd0, 24, 0, rd);
    check("R4 main read", rd, 24'h123456);
    check("R7 rdy_no after main read", {23'd0, rdy_n}, 24'd1);
    txn(8'h43, 24'd0, 24, 0, rd);
    check("R7 main reread", rd, 24'h123456);

    load_aux(16'hBEEF);
    load_main(24'h00C3F0);
    load_main(24'hF00F81);
    txn(8'h41, 24'd0, 8, -1, rd);
    check("R7 status both ready", rd, 24'h000003);
    txn(8'h44, 24'd0, 16, 1, rd);
    check("R4 aux read", rd, 24'h00BEEF);
    check("R7 rdy_no still low, main pending", {23'd0, rdy_n}, 24'd0);
    txn(8'h43, 24'd0, 24, 0, rd);
    check("R5 main latest word", rd, 24'hF00F81);

    // R2: reserved bit set, command ignored
    txn(8'h82, 24'd0, 0, -1, junk);
    txn(8'h42, 24'd0, 8, -1, rd);
    check("R2 bad command ignored", rd, 24'h0000A5);
    txn(8'h07, 24'd0, 0, -1, junk);
    txn(8'h42, 24'd0, 8, -1, rd);
    check("R2 unknown write address ignored", rd, 24'h0000A5);

    // R10: abort mid write
    cs_n = 1'b0;
    ticks(2);
    xfer(24'h02, 8, -1, junk);
    xfer(24'hF, 4, -1, junk);
    cs_n = 1'b1;
    ticks(2);
    txn(8'h42, 24'd0, 8, -1, rd);
    check("R10 aborted write left mode", rd, 24'h0000A5);

    // R8: three-wire, select stays low
    load_main(24'h5A5A01);
    cs_n = 1'b0;
    ticks(2);
    xfer(24'h02, 8, -1, junk);
    xfer(24'h3C, 8, -1, junk);
    xfer(24'h42, 8, -1, junk);
    xfer(24'd0, 8, -1, rd);
    check("R8 three-wire mode readback", rd, 24'h00003C);
    xfer(24'h43, 8, -1, junk);
    xfer(24'd0, 24, 0, rd);
    check("R8 three-wire main read", rd, 24'h5A5A01);
    ticks(2);
    check("R8 rdy_no after three-wire read", {23'd0, rdy_n}, 24'd1);
    cs_n = 1'b1;
    ticks(2);

    // R9: frame sync, clock runs while deselected
    load_aux(16'h8001);
    cs_n = 1'b0;
    ticks(2);
    xfer(24'h44, 8, -1, junk);
    cs_n = 1'b1;
    repeat (3) begin
      sclk = 1'b0; ticks(2); sclk = 1'b1; ticks(2);
    end
    cs_n = 1'b0;
    ticks(2);
    check("R9 MSB on select fall", {23'd0, sdo}, 24'd1);
    xfer(24'd0, 16, 1, rd);
    check("R9 frame aux read", rd, 24'h008001);
    cs_n = 1'b1;
    ticks(4);
    check("R7 rdy_no idle", {23'd0, rdy_n}, 24'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule